// File: doc/BRIEF.md
# Hardware Reset Sequencer with Ready/Busy Recovery

This block sits between the active-low hardware reset pin of a flash-style memory device and the device's internal machinery. It filters the pin so that short glitches do nothing. It declares a reset once the pin has stayed low for a minimum number of clock cycles. When a reset is declared, the block aborts whatever internal program or erase algorithm is running. It holds the command decoder in array-read mode, tristates the data outputs and gates off all incoming read and write commands.

The ready/busy output is held low after a declared reset for a recovery interval. Its length depends on whether an embedded program or erase was active at the moment the reset was declared: a long interval if one was, a short one if not. Once the pin is sampled high again, read access returns only after a further release delay. Outside of reset, ready/busy follows the embedded-operation flag, and the output-enable input controls the data output drivers. All timings are parameters counted in clock cycles.

Top module: `hwrst_seq`

## Requirements
- R1: A low period on `rst_pin_n` that lasts fewer than `PULSE_MIN` consecutive sampled cycles has no effect: no abort pulse, and the phase, output and ready/busy behaviour stay as in normal operation.
- R2: A reset is declared at the clock edge that samples `rst_pin_n` low for the `PULSE_MIN`-th consecutive time. `algo_abort` is high for exactly the one cycle that follows that edge, and is raised once per low period.
- R3: From the cycle after a declared reset until read access returns, `dq_hiz` is high whatever `oe_n` is.
- R4: While read access is withheld (declared reset held, or release delay running), `rd_take` and `wr_take` stay low whatever `cmd_rd` and `cmd_wr` are.
- R5: `csm_hold_read` (1 = command state machine forced to array-read) is high from the cycle after a declared reset until the first edge that samples `rst_pin_n` high.
- R6: If `embedded_busy` is 1 at the declaring edge, `rdy_busy_n` is 0 (busy) for exactly `REC_LONG` cycles after that edge.
- R7: If `embedded_busy` is 0 at the declaring edge, `rdy_busy_n` is 0 for exactly `REC_SHORT` cycles after that edge.
- R8: After the held reset is released, `read_ok` returns to 1 exactly `RH_DLY` cycles after the first edge that samples the pin high. A new declared reset during that delay returns the block to the held state.
- R9: `oe_n` = 1 forces `dq_hiz` high at any time, and has no effect on `rdy_busy_n`.
- R10: In normal operation (no reset held, no release delay, no recovery running), `rdy_busy_n` equals the inverse of `embedded_busy`, and `rd_take`/`wr_take` follow `cmd_rd`/`cmd_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| rst_pin_n | input | 1 | Device hardware reset pin, active low, sampled each edge |
| embedded_busy | input | 1 | 1 while an embedded program or erase algorithm runs |
| oe_n | input | 1 | Output enable, active low |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| algo_abort | output | 1 | One-cycle abort request to the embedded algorithm |
| csm_hold_read | output | 1 | Forces the command state machine into array-read mode |
| dq_hiz | output | 1 | 1 = data output pins in high impedance |
| rd_take | output | 1 | Read command accepted |
| wr_take | output | 1 | Write command accepted |
| rdy_busy_n | output | 1 | Ready/busy, 1 = ready, 0 = busy |
| read_ok | output | 1 | 1 = array reads permitted |

## Verification
A glitch filter counter that drifts shows up as an abort pulse on a sub-minimum low pulse, or as a missing or late one, within one cycle of the `PULSE_MIN`-th low sample. A wrong captured busy flag or recovery count shows at `rdy_busy_n` as a busy window of the wrong length. The error becomes visible at the edge where the two windows first differ: `REC_SHORT` cycles after the declaring edge. A stuck phase shows at once on `dq_hiz`, the command gates or `read_ok`. An off-by-one in the release delay shows on `read_ok` exactly `RH_DLY` cycles after the pin is sampled high.

// File: rtl/hwrst_pkg.sv
package hwrst_pkg;

  typedef enum logic [1:0] {
    PH_NORM    = 2'd0,
    PH_HELD    = 2'd1,
    PH_RELEASE = 2'd2
  } rst_phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hwrst_qualifier.sv
module hwrst_qualifier #(
  parameter int unsigned PULSE_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lo,
  output logic valid_o
);

  localparam int unsigned LOW_W = $clog2(PULSE_MIN + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(PULSE_MIN - 1);
  localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(PULSE_MIN);

  logic [LOW_W-1:0] low_cnt_q;
  logic [LOW_W-1:0] low_cnt_d;

  // count consecutive low samples, saturating once the pulse is qualified
  always_comb begin
    if (!pin_lo) begin
      low_cnt_d = '0;
    end else if (low_cnt_q == LOW_SAT) begin
      low_cnt_d = low_cnt_q;
    end else begin
      low_cnt_d = low_cnt_q + LOW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
    end else begin
      low_cnt_q <= low_cnt_d;
    end
  end

  assign valid_o = pin_lo && (low_cnt_q == LOW_LAST);

  // R2
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R1
  high_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_lo |=> (low_cnt_q == '0));

endmodule

// File: rtl/hwrst_phase_fsm.sv
module hwrst_phase_fsm
  import hwrst_pkg::*;
#(
  parameter int unsigned RH_DLY = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_lo,
  input  logic       valid,
  output rst_phase_e phase_o,
  output logic       abort_o
);

  localparam int unsigned RH_W = $clog2(RH_DLY + 1);
  localparam logic [RH_W-1:0] RH_LOAD = RH_W'(RH_DLY);
  localparam logic [RH_W-1:0] RH_ONE  = RH_W'(1);

  rst_phase_e      phase_q, phase_d;
  logic [RH_W-1:0] rh_q, rh_d;
  logic            rh_en;
  logic            abort_q;

  always_comb begin
    phase_d = phase_q;
    rh_d    = rh_q;
    rh_en   = 1'b0;
    if (valid) begin
      phase_d = PH_HELD;
    end else begin
      unique case (phase_q)
        PH_HELD: begin
          if (!pin_lo) begin
            phase_d = PH_RELEASE;
            rh_d    = RH_LOAD;
            rh_en   = 1'b1;
          end
        end
        PH_RELEASE: begin
          rh_en = 1'b1;
          if (rh_q <= RH_ONE) begin
            phase_d = PH_NORM;
            rh_d    = '0;
          end else begin
            rh_d = rh_q - RH_ONE;
          end
        end
        default: phase_d = PH_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_NORM;
      abort_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      abort_q <= valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_q <= '0;
    end else if (rh_en) begin
      rh_q <= rh_d;
    end
  end

  assign phase_o = phase_q;
  assign abort_o = abort_q;

  // R2
  enter_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (phase_q == PH_HELD) && abort_q);

  // R2
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HELD) && !pin_lo |=> (phase_q == PH_RELEASE));

  // R8
  no_spurious_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_HELD) && !valid |=> (phase_q != PH_HELD));

endmodule

// File: rtl/hwrst_recovery.sv
module hwrst_recovery #(
  parameter int unsigned REC_LONG  = 40,
  parameter int unsigned REC_SHORT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic op_busy,
  output logic busy_o
);

  localparam int unsigned REC_MAX = hwrst_pkg::max_u(REC_LONG, REC_SHORT);
  localparam int unsigned REC_W   = $clog2(REC_MAX + 1);
  localparam logic [REC_W-1:0] LOAD_LONG  = REC_W'(REC_LONG);
  localparam logic [REC_W-1:0] LOAD_SHORT = REC_W'(REC_SHORT);

  logic [REC_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             long_q, long_d;

  // the busy flag seen at the declaring edge picks the recovery length
  always_comb begin
    cnt_d  = cnt_q;
    long_d = long_q;
    cnt_en = 1'b0;
    if (valid) begin
      long_d = op_busy;
      cnt_d  = op_busy ? LOAD_LONG : LOAD_SHORT;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - REC_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R6
  long_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op_busy |=> (cnt_q == LOAD_LONG) && long_q);

  // R7
  short_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !op_busy |=> (cnt_q == LOAD_SHORT) && !long_q);

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - REC_W'(1)));

endmodule

// File: rtl/hwrst_seq.sv
module hwrst_seq
  import hwrst_pkg::*;
#(
  parameter int unsigned PULSE_MIN = 4,
  parameter int unsigned REC_LONG  = 40,
  parameter int unsigned REC_SHORT = 10,
  parameter int unsigned RH_DLY    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic embedded_busy,
  input  logic oe_n,
  input  logic cmd_rd,
  input  logic cmd_wr,
  output logic algo_abort,
  output logic csm_hold_read,
  output logic dq_hiz,
  output logic rd_take,
  output logic wr_take,
  output logic rdy_busy_n,
  output logic read_ok
);

  logic       pin_lo;
  logic       rst_valid;
  logic       rec_busy;
  rst_phase_e phase;
  logic       in_norm;

  assign pin_lo = !rst_pin_n;

  hwrst_qualifier #(
    .PULSE_MIN (PULSE_MIN)
  ) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_lo  (pin_lo),
    .valid_o (rst_valid)
  );

  hwrst_phase_fsm #(
    .RH_DLY (RH_DLY)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_lo  (pin_lo),
    .valid   (rst_valid),
    .phase_o (phase),
    .abort_o (algo_abort)
  );

  hwrst_recovery #(
    .REC_LONG  (REC_LONG),
    .REC_SHORT (REC_SHORT)
  ) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (rst_valid),
    .op_busy (embedded_busy),
    .busy_o  (rec_busy)
  );

  assign in_norm       = (phase == PH_NORM);
  assign csm_hold_read = (phase == PH_HELD);
  assign read_ok       = in_norm;
  assign dq_hiz        = oe_n || !in_norm;
  assign rd_take       = cmd_rd && in_norm;
  assign wr_take       = cmd_wr && in_norm;
  assign rdy_busy_n    = !(rec_busy || (embedded_busy && in_norm));

  // R4
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !read_ok |-> !rd_take && !wr_take);

  // R3
  hiz_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    algo_abort |-> dq_hiz && csm_hold_read);

  // R9
  oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dq_hiz);

  // R6
  busy_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    algo_abort |-> !rdy_busy_n);

endmodule

// File: tb/sim_hwrst_seq.sv
module sim_hwrst_seq;

  localparam int CLK_P     = 10;
  localparam int PULSE_MIN = 4;
  localparam int REC_LONG  = 40;
  localparam int REC_SHORT = 10;
  localparam int RH_DLY    = 6;

  logic clk, rst_n, rst_pin_n, embedded_busy, oe_n, cmd_rd, cmd_wr;
  logic algo_abort, csm_hold_read, dq_hiz, rd_take, wr_take, rdy_busy_n, read_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state, kept from the requirements
  int m_low, m_ph, m_rh, m_rec;   // m_ph: 0 normal, 1 held, 2 release delay
  bit m_abort;

  hwrst_seq #(
    .PULSE_MIN (PULSE_MIN),
    .REC_LONG  (REC_LONG),
    .REC_SHORT (REC_SHORT),
    .RH_DLY    (RH_DLY)
  ) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_pin_n     (rst_pin_n),
    .embedded_busy (embedded_busy),
    .oe_n          (oe_n),
    .cmd_rd        (cmd_rd),
    .cmd_wr        (cmd_wr),
    .algo_abort    (algo_abort),
    .csm_hold_read (csm_hold_read),
    .dq_hiz        (dq_hiz),
    .rd_take       (rd_take),
    .wr_take       (wr_take),
    .rdy_busy_n    (rdy_busy_n),
    .read_ok       (read_ok)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_hiz();
    return oe_n || (m_ph != 0);              // R3, R9
  endfunction

  function automatic bit exp_rdy();
    return !((m_rec > 0) || (embedded_busy && m_ph == 0));  // R6, R7, R10
  endfunction

  task automatic check_all();
    chk("R2",  "algo_abort",    algo_abort,    m_abort);
    chk("R5",  "csm_hold_read", csm_hold_read, m_ph == 1);
    chk("R3",  "dq_hiz",        dq_hiz,        exp_hiz());
    chk("R4",  "rd_take",       rd_take,       cmd_rd && m_ph == 0);
    chk("R4",  "wr_take",       wr_take,       cmd_wr && m_ph == 0);
    chk("R6",  "rdy_busy_n",    rdy_busy_n,    exp_rdy());
    chk("R8",  "read_ok",       read_ok,       m_ph == 0);
  endtask

  task automatic model_edge();
    bit lo, trig;
    lo   = !rst_pin_n;
    trig = lo && (m_low == PULSE_MIN - 1);     // R1, R2
    m_abort = trig;
    if (trig) m_rec = embedded_busy ? REC_LONG : REC_SHORT;  // R6, R7
    else if (m_rec > 0) m_rec--;
    if (trig) m_ph = 1;
    else if (m_ph == 1 && !lo) begin m_ph = 2; m_rh = RH_DLY; end
    else if (m_ph == 2) begin
      if (m_rh <= 1) m_ph = 0; else m_rh--;   // R8
    end
    m_low = lo ? m_low + 1 : 0;
  endtask

  // inputs are already set after a falling edge; check, then let one edge pass
  task automatic cycle();
    #1;
    check_all();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
  endtask

  task automatic set_in(input bit pin, input bit busy, input bit oe, input bit rd, input bit wr);
    rst_pin_n = pin; embedded_busy = busy; oe_n = oe; cmd_rd = rd; cmd_wr = wr;
  endtask

  task automatic low_pulse(input int width, input bit busy);
    for (int i = 0; i < width; i++) begin
      set_in(1'b0, busy, 1'b0, 1'b1, 1'b1);
      cycle();
    end
    for (int i = 0; i < REC_LONG + RH_DLY + 4; i++) begin
      set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      cycle();
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    int seen_abort;
    void'($urandom(32'd2024));
    m_low = 0; m_ph = 0; m_rh = 0; m_rec = 0; m_abort = 0;
    rst_n = 1'b0;
    set_in(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    // reset state
    for (int i = 0; i < 3; i++) cycle();
    rst_n = 1'b1;
    // R10 normal operation
    set_in(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    cycle();
    chk("R10", "rdy follows busy", rdy_busy_n, 1'b0);
    set_in(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    cycle();
    chk("R9", "oe_n forces hiz", dq_hiz, 1'b1);
    // R1 glitch one short of the minimum
    seen_abort = 0;
    for (int i = 0; i < PULSE_MIN - 1; i++) begin
      set_in(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      cycle();
      seen_abort += algo_abort;
    end
    set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    cycle();
    chk("R1", "no abort after glitch", seen_abort != 0 || algo_abort, 1'b0);
    chk("R1", "read_ok kept", read_ok, 1'b1);
    // R6 long recovery: count busy cycles after the declaring edge
    for (int i = 0; i < PULSE_MIN; i++) begin
      set_in(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      cycle();
    end
    busy_cnt = 0;
    for (int i = 0; i < REC_LONG + 5; i++) begin
      set_in(i < 3 ? 1'b0 : 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      #1;
      if (!rdy_busy_n) busy_cnt++;
      cycle();
    end
    chk("R6", "long busy length", busy_cnt == REC_LONG, 1'b1);
    // R7 short recovery
    for (int i = 0; i < PULSE_MIN; i++) begin
      set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cycle();
    end
    busy_cnt = 0;
    for (int i = 0; i < REC_LONG + 5; i++) begin
      set_in(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      #1;
      if (!rdy_busy_n) busy_cnt++;
      cycle();
    end
    chk("R7", "short busy length", busy_cnt == REC_SHORT, 1'b1);
    // R8 re-declared reset during release delay
    for (int i = 0; i < PULSE_MIN + 2; i++) begin set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b0); cycle(); end
    for (int i = 0; i < 2; i++) begin set_in(1'b1, 1'b0, 1'b0, 1'b0, 1'b0); cycle(); end
    for (int i = 0; i < PULSE_MIN; i++) begin set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b0); cycle(); end
    #1;
    chk("R8", "held again after repeat", csm_hold_read, 1'b1);
    low_pulse(1, 1'b1);
    low_pulse(PULSE_MIN, 1'b1);
    low_pulse(PULSE_MIN + 7, 1'b0);
    // constrained random phase
    for (int k = 0; k < 300; k++) begin
      int width, gap;
      width = 1 + ($urandom % (PULSE_MIN + 6));
      gap   = 1 + ($urandom % (REC_LONG + RH_DLY + 8));
      for (int i = 0; i < width; i++) begin
        set_in(1'b0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
        cycle();
      end
      for (int i = 0; i < gap; i++) begin
        set_in(1'b1, ($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2);
        cycle();
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule